// File: doc/BRIEF.md
# Power-On Reset Sequencer with Watchdog

This block sequences reset for a small microcontroller. A power-on pulse, or the asynchronous reset input, starts a stabilization window. During that window the CPU and module clocks stay gated off, and the external reset pin is driven low. After the window ends, the pin is released after a short fixed offset. The CPU is released at a second, longer offset.

A watchdog counter runs while the CPU is released. Software keeps it from overflowing by writing any value to the service address. If it does overflow, the block forces an internal reset. That reset repeats the two release offsets but skips the stabilization window.

A two-bit cause register records the source of the last reset. Bit 0 means power-on and bit 1 means watchdog. Software reads it through the same simple bus port it uses to service the watchdog.

Top module: `rst_seq_top`

## Requirements
- R1: While rst_ni is low, clk_en_o, rst_pin_no and cpu_rst_no are 0, and the cause register holds power-on=1, watchdog=0.
- R2: After rst_ni is released or a por_i pulse is sampled, clk_en_o stays 0 for STAB_CYC (default 4096) clock cycles and then goes to 1.
- R3: rst_pin_no is 0 throughout the stabilization window and rises PIN_OFS (default 32) cycles after the window ends.
- R4: cpu_rst_no rises CPU_OFS (default 64) cycles after the window ends, and never before rst_pin_no.
- R5: The watchdog advances only while the CPU is released. After 2^WDT_W cycles without service, rst_pin_no and cpu_rst_no fall in the same cycle while clk_en_o stays 1. The pin then rises PIN_OFS cycles later and the CPU rises CPU_OFS cycles later.
- R6: A watchdog reset sets the watchdog bit and clears the power-on bit. A bus read at STAT_ADDR (default 0xFE01) returns {6'b0, watchdog, power_on}, and a read at any other address returns 0.
- R7: A bus write of any data to SVC_ADDR (0xFFFF) restarts the watchdog count from zero. Writes to any other address leave the count unchanged.
- R8: A service write sampled in the same cycle the watchdog would overflow wins: no reset occurs, and the count restarts from zero.
- R9: A por_i pulse at any point, including inside the stabilization or release phase, restarts the sequence from the start of the window and sets the cause to power-on only.
- R10: Reading the cause register, or writing to STAT_ADDR, leaves its contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, treated as power-on |
| por_i | input | 1 | Power-on pulse, sampled on the clock |
| bus_addr_i | input | AW (16) | Bus address |
| bus_wdata_i | input | DW (8) | Bus write data (content ignored) |
| bus_we_i | input | 1 | Bus write strobe |
| bus_rdata_o | output | DW (8) | Bus read data, combinational on address |
| clk_en_o | output | 1 | Clock enable for CPU and modules |
| rst_pin_no | output | 1 | External reset pin drive, low = asserted |
| cpu_rst_no | output | 1 | CPU reset, high = released |
| stat_por_o | output | 1 | Cause bit: power-on |
| stat_cop_o | output | 1 | Cause bit: watchdog |

## Verification
The watchdog overflow and a service write can fall in the same cycle. The bench provokes this case by timing a write to 0xFFFF so that it is sampled exactly on the edge where the count reaches all ones. It then judges the result in two ways. First, no reset edge may appear at that point. Second, the next overflow must arrive a full 2^WDT_W cycles later, which proves the count restarted on the contested edge. A power-on pulse inside an already running stabilization window is a second collision, and the bench judges it by the shifted release times.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_STAB = 2'd0,
    ST_REL  = 2'd1,
    ST_RUN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYC = 4096,
  parameter int PIN_OFS  = 32,
  parameter int CPU_OFS  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic wdt_ovf_i,
  output logic clk_en_o,
  output logic pin_rel_o,
  output logic cpu_rel_o,
  output logic run_o
);
  localparam int MAXC = (STAB_CYC > CPU_OFS) ? STAB_CYC : CPU_OFS;
  localparam int CW   = $clog2(MAXC + 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_STAB;
      cnt_q <= '0;
    end else if (por_i) begin
      st_q  <= ST_STAB;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_STAB: begin
          if (cnt_q == CW'(STAB_CYC - 1)) begin
            st_q  <= ST_REL;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_REL: begin
          if (cnt_q == CW'(CPU_OFS - 1)) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          // internal reset skips stabilization
          if (wdt_ovf_i) begin
            st_q  <= ST_REL;
            cnt_q <= '0;
          end
        end
        default: begin
          st_q  <= ST_STAB;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign clk_en_o  = (st_q != ST_STAB);
  assign run_o     = (st_q == ST_RUN);
  assign cpu_rel_o = run_o;
  assign pin_rel_o = run_o || ((st_q == ST_REL) && (cnt_q >= CW'(PIN_OFS)));
endmodule

// File: rtl/rst_seq_wdt.sv
module rst_seq_wdt #(
  parameter int WDT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic run_i,
  input  logic svc_i,
  output logic ovf_o
);
  logic [WDT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (por_i || !run_i || svc_i)    cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  // service in the same cycle takes priority over overflow
  assign ovf_o = run_i && !svc_i && !por_i && (&cnt_q);
endmodule

// File: rtl/rst_seq_stat.sv
module rst_seq_stat #(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [15:0] STAT_ADDR = 16'hFE01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_i,
  input  logic          wdt_ovf_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rdata_o,
  output logic          por_o,
  output logic          cop_o
);
  logic por_q, cop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q <= 1'b1;
      cop_q <= 1'b0;
    end else if (por_i) begin
      por_q <= 1'b1;
      cop_q <= 1'b0;
    end else if (wdt_ovf_i) begin
      por_q <= 1'b0;
      cop_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_addr_i == AW'(STAT_ADDR)) begin
      rdata_o[0] = por_q;
      rdata_o[1] = cop_q;
    end
  end

  assign por_o = por_q;
  assign cop_o = cop_q;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int          STAB_CYC  = 4096,
  parameter int          PIN_OFS   = 32,
  parameter int          CPU_OFS   = 64,
  parameter int          WDT_W     = 16,
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [15:0] SVC_ADDR  = 16'hFFFF,
  parameter logic [15:0] STAT_ADDR = 16'hFE01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic          bus_we_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          clk_en_o,
  output logic          rst_pin_no,
  output logic          cpu_rst_no,
  output logic          stat_por_o,
  output logic          stat_cop_o
);
  logic run, svc, wdt_ovf, pin_rel, cpu_rel;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata_i;  // any value services the watchdog
  assign svc = bus_we_i && (bus_addr_i == AW'(SVC_ADDR));

  rst_seq_fsm #(
    .STAB_CYC(STAB_CYC),
    .PIN_OFS (PIN_OFS),
    .CPU_OFS (CPU_OFS)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_i    (por_i),
    .wdt_ovf_i(wdt_ovf),
    .clk_en_o (clk_en_o),
    .pin_rel_o(pin_rel),
    .cpu_rel_o(cpu_rel),
    .run_o    (run)
  );

  rst_seq_wdt #(.WDT_W(WDT_W)) u_wdt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .por_i (por_i),
    .run_i (run),
    .svc_i (svc),
    .ovf_o (wdt_ovf)
  );

  rst_seq_stat #(
    .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR)
  ) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_i    (por_i),
    .wdt_ovf_i(wdt_ovf),
    .rd_addr_i(bus_addr_i),
    .rdata_o  (bus_rdata_o),
    .por_o    (stat_por_o),
    .cop_o    (stat_cop_o)
  );

  assign rst_pin_no = pin_rel;
  assign cpu_rst_no = cpu_rel;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int          AW       = 16,
  parameter logic [15:0] SVC_ADDR = 16'hFFFF
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          por_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_we_i,
  input logic          clk_en_o,
  input logic          rst_pin_no,
  input logic          cpu_rst_no,
  input logic          stat_por_o,
  input logic          stat_cop_o
);
  AST_GATED_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> (!rst_pin_no && !cpu_rst_no)); // R3

  AST_PIN_LEADS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> (rst_pin_no && $past(rst_pin_no))); // R4

  AST_COP_SKIPS_STAB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cpu_rst_no) && !$past(por_i)) |-> (clk_en_o && !rst_pin_no && stat_cop_o)); // R5

  AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({stat_cop_o, stat_por_o}) == 1); // R6

  AST_SVC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == AW'(SVC_ADDR) && cpu_rst_no && !por_i) |=> cpu_rst_no); // R8

  AST_POR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (!clk_en_o && !rst_pin_no && !cpu_rst_no && stat_por_o && !stat_cop_o)); // R9

  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rst_no && !por_i) |=> ($stable({stat_cop_o, stat_por_o}) || $fell(cpu_rst_no))); // R10
endmodule

bind rst_seq_top rst_seq_chk #(.AW(AW), .SVC_ADDR(SVC_ADDR)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_i     (por_i),
  .bus_addr_i(bus_addr_i),
  .bus_we_i  (bus_we_i),
  .clk_en_o  (clk_en_o),
  .rst_pin_no(rst_pin_no),
  .cpu_rst_no(cpu_rst_no),
  .stat_por_o(stat_por_o),
  .stat_cop_o(stat_cop_o)
);

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;
  localparam int STAB = 4096;
  localparam int PINO = 32;
  localparam int CPUO = 64;
  localparam int WW   = 8;
  localparam int WPER = 1 << WW;

  // event kinds
  localparam int K_CE_R = 0, K_CE_F = 1, K_PIN_R = 2, K_PIN_F = 3, K_CPU_R = 4, K_CPU_F = 5;

  typedef struct { int kind; int cyc; string req; } ev_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        por = 0;
  logic [15:0] addr = 16'hFE01;
  logic [7:0]  wdata = 8'h00;
  logic        we = 0;
  logic [7:0]  rdata;
  logic        ce, pin_n, cpu_n, s_por, s_cop;

  int total = 0, bad = 0, cyc = 0;
  bit mon_en = 0, done = 0;
  logic p_ce, p_pin, p_cpu;
  ev_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_seq_top #(.STAB_CYC(STAB), .PIN_OFS(PINO), .CPU_OFS(CPUO), .WDT_W(WW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .clk_en_o(ce), .rst_pin_no(pin_n),
    .cpu_rst_no(cpu_n), .stat_por_o(s_por), .stat_cop_o(s_cop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int at, input string req);
    ev_t e;
    e.kind = kind; e.cyc = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(0, "unexpected edge", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind, e.req, kind, e.kind);
      chk(e.cyc == cyc, e.req, cyc, e.cyc);
    end
  endtask

  // monitor: turns output edges into events and scores them
  always @(negedge clk) begin
    if (mon_en) begin
      if (ce    && !p_ce)  observe(K_CE_R);
      if (!ce   &&  p_ce)  observe(K_CE_F);
      if (pin_n && !p_pin) observe(K_PIN_R);
      if (!pin_n &&  p_pin) observe(K_PIN_F);
      if (cpu_n && !p_cpu) observe(K_CPU_R);
      if (!cpu_n &&  p_cpu) observe(K_CPU_F);
    end
    p_ce = ce; p_pin = pin_n; p_cpu = cpu_n;
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic bus_wr(input logic [15:0] a);
    addr = a; we = 1; wdata = wdata + 8'h3B;
    @(negedge clk);
    we = 0; addr = 16'hFE01;
  endtask

  task automatic pulse_por();
    por = 1;
    @(negedge clk);
    por = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t, r, s, r2, p, q;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce == 0, "R1 clk_en", ce, 0);
    chk(pin_n == 0, "R1 pin", pin_n, 0);
    chk(cpu_n == 0, "R1 cpu", cpu_n, 0);
    chk(rdata == 8'h01, "R1 cause read", rdata, 1);
    mon_en = 1;

    // R2/R3/R4 sequence from reset release
    t = cyc;
    rst_n = 1;
    push(K_CE_R,  t + STAB,        "R2 clk_en rise");
    push(K_PIN_R, t + STAB + PINO, "R3 pin release");
    push(K_CPU_R, t + STAB + CPUO, "R4 cpu release");
    wait_until(t + STAB - 2);
    chk(pin_n == 0 && ce == 0, "R3 pin low in window", pin_n, 0);
    r = t + STAB + CPUO;
    wait_until(r + 1);
    drained("R4 release events");

    // R7 periodic service keeps CPU running
    for (int i = 0; i < 8; i++) begin
      wait_until(cyc + 100);
      bus_wr(16'hFFFF);
    end
    s = cyc - 1;  // cycle the last service write was driven
    chk(cpu_n == 1, "R7 service holds run", cpu_n, 1);
    // R7 other addresses do not service; R10 status writes ignored
    push(K_PIN_F, s + WPER + 1,        "R5 pin fall on overflow");
    push(K_CPU_F, s + WPER + 1,        "R5 cpu fall on overflow");
    push(K_PIN_R, s + WPER + 1 + PINO, "R5 pin release after overflow");
    push(K_CPU_R, s + WPER + 1 + CPUO, "R5 cpu release after overflow");
    for (int i = 0; i < 4; i++) begin
      wait_until(cyc + 40);
      bus_wr(16'hFFFE);
      bus_wr(16'hFE01);
    end
    wait_until(s + WPER + 3);
    chk(ce == 1, "R5 clk_en stays on", ce, 1);
    chk(rdata == 8'h02, "R6 cause after overflow", rdata, 2);
    chk(s_cop == 1 && s_por == 0, "R6 cause bits", {s_cop, s_por}, 2);
    addr = 16'h1234;
    #1;
    chk(rdata == 8'h00, "R6 other address reads 0", rdata, 0);
    addr = 16'hFE01;
    r2 = s + WPER + 1 + CPUO;
    wait_until(r2 + 1);
    drained("R5 overflow events");

    // R8 service in the overflow cycle wins
    wait_until(r2 + WPER - 1);
    bus_wr(16'hFFFF);
    push(K_PIN_F, r2 + 2 * WPER,        "R8 next overflow");
    push(K_CPU_F, r2 + 2 * WPER,        "R8 next overflow");
    push(K_PIN_R, r2 + 2 * WPER + PINO, "R8 pin release");
    push(K_CPU_R, r2 + 2 * WPER + CPUO, "R8 cpu release");
    wait_until(r2 + WPER + 2);
    chk(cpu_n == 1, "R8 no reset on contested edge", cpu_n, 1);
    wait_until(r2 + 2 * WPER + CPUO + 1);
    drained("R8 events");

    // R10 repeated reads leave cause unchanged
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rdata == 8'h02, "R10 read stable", rdata, 2);
    end

    // R9 power-on pulse while running, then again inside the window
    wait_until(cyc + 20);
    p = cyc;
    push(K_CE_F,  p + 1, "R9 clk_en gated");
    push(K_PIN_F, p + 1, "R9 pin low");
    push(K_CPU_F, p + 1, "R9 cpu held");
    pulse_por();
    @(negedge clk);
    chk(rdata == 8'h01, "R9 cause power-on", rdata, 1);
    drained("R9 restart events");
    wait_until(p + 2000);
    q = cyc;
    pulse_por();
    push(K_CE_R,  q + 1 + STAB,        "R9 window restarted");
    push(K_PIN_R, q + 1 + STAB + PINO, "R9 pin after restart");
    push(K_CPU_R, q + 1 + STAB + CPUO, "R9 cpu after restart");
    wait_until(q + STAB + CPUO + 3);
    drained("R9 second pulse events");
    chk(s_por == 1 && s_cop == 0, "R9 cause bits", {s_cop, s_por}, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule